// File: doc/BRIEF.md
# USB Device Endpoint Register Block

This block is the software-visible register set of a USB device-mode controller with sixteen endpoint numbers, each carrying an OUT and an IN direction. Software reaches it over a simple 32-bit request bus with a registered read return. The packet engine on the hardware side sees the requests software has posted: which endpoint buffers to prime or flush, which endpoints are enabled or stalled, their transfer types, one-cycle data-toggle reset pulses, the device address, the run state and whether device mode is selected. It reports back through pulse inputs: prime and flush acknowledges, buffer-ready changes, transfer completions, SETUP arrivals and bus-level events.

Every per-endpoint bitmap packs OUT endpoints in the low half and IN endpoints in the upper half, so one word covers all 32 buffers. Prime and flush bits are set by software and cleared by the hardware handshake, which lets software poll them until they read zero. Event bitmaps are write-one-to-clear. If an event and a clear hit the same bit in the same cycle, the event is kept. A new device address can be staged so that it only takes effect once the status stage of the current control transfer, an IN on endpoint 0, has finished.

Top module: `usbd_ep_regs`

## Requirements
- R1: Byte offsets: 0x00 command, 0x04 status, 0x08 address, 0x0C mode, 0x10 setup bitmap, 0x14 prime, 0x18 flush, 0x1C ready, 0x20 completion, 0x40+4*n control word of endpoint n. A read returns its data on `bus_rdata` with `bus_rvalid` high in the cycle after the request. Unmapped offsets read 0. After reset every register reads 0, except control word 0.
- R2: In the prime, flush, ready and completion bitmaps, bit n is OUT endpoint n and bit 16+n is IN endpoint n. Writing ones to the prime register sets those bits, and zeros leave bits unchanged. `prime_req` mirrors the register.
- R3: A prime bit clears in the cycle after its `hw_prime_ack` bit pulses. Without an acknowledge it stays set.
- R4: The flush register behaves the same way: write-one sets, `flush_req` mirrors it, and `hw_flush_ack` clears it.
- R5: The ready bitmap is read-only. `hw_ready_set` sets its bits and `hw_ready_clr` clears them. It is not tied to the prime bits.
- R6: The completion bitmap (set by `hw_complete`) and the setup bitmap (set by `hw_setup`, bits 15:0 only, bits 31:16 read 0) are write-one-to-clear. An event arriving in the same cycle as a clear of the same bit leaves the bit set.
- R7: Status bit 6 is bus reset, bit 2 is port change, bit 1 is error, and bit 0 is set by any completion or setup event. The bits are write-one-to-clear, and an event wins over a clear in the same cycle.
- R8: Control word n layout: bit 23 IN enable, bits 19:18 IN type (0 control, 1 isochronous, 2 bulk, 3 interrupt), bit 16 IN stall, and bits 7, 3:2 and 0 the same fields for OUT. These drive `ep_en`, `ep_type` and `ep_stall` at index n for OUT and 16+n for IN. Writing 1 to bit 22 or bit 6 pulses `ep_toggle_rst` bit 16+n or bit n for exactly one cycle after the write. Bits 22 and 6 read 0.
- R9: Control word 0 always reads as an enabled control endpoint in both directions (0x00800080 plus its stall bits). Only bits 16 and 0 are writable.
- R10: The address register holds the address in bits 31:25 and the stage flag in bit 24. A write with bit 24 clear updates `dev_addr` in the next cycle. A write with bit 24 set leaves `dev_addr` unchanged until the cycle after an `hw_ep0_in_done` pulse; the stage flag reads 1 until then and 0 afterwards.
- R11: Command bit 0 is `run`. Writing 1 to command bit 1 clears all bitmaps, control words, address, mode, status and run. Bit 1 reads 0.
- R12: Mode bits 1:0 read back as written. `dev_mode` is high exactly when they hold 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Register access request |
| bus_we | input | 1 | 1 write, 0 read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after request |
| hw_prime_ack | input | 2*NUM_EP | Prime handshake done, per buffer |
| hw_flush_ack | input | 2*NUM_EP | Flush handshake done, per buffer |
| hw_ready_set | input | 2*NUM_EP | Buffer became ready |
| hw_ready_clr | input | 2*NUM_EP | Buffer no longer ready |
| hw_complete | input | 2*NUM_EP | Transfer completed, per buffer |
| hw_setup | input | NUM_EP | SETUP packet received, per endpoint |
| hw_bus_reset | input | 1 | Bus reset seen |
| hw_port_change | input | 1 | Port state changed |
| hw_error | input | 1 | Transfer error |
| hw_ep0_in_done | input | 1 | Control IN on endpoint 0 finished |
| prime_req | output | 2*NUM_EP | Pending prime requests |
| flush_req | output | 2*NUM_EP | Pending flush requests |
| ep_en | output | 2*NUM_EP | Endpoint enables |
| ep_stall | output | 2*NUM_EP | Endpoint stalls |
| ep_type | output | 4*NUM_EP | Two-bit transfer type per buffer |
| ep_toggle_rst | output | 2*NUM_EP | Data toggle reset pulses |
| dev_addr | output | 7 | Effective device address |
| run | output | 1 | Controller run bit |
| dev_mode | output | 1 | Device mode selected |

## Verification
The bench builds the block with its defaults: NUM_EP of 16, which fills all 32 bitmap bits and puts IN endpoints at bit 16, and ADDR_W of 8, which covers the whole control word array. With these values it can reach the upper-half IN bits, the hardwired endpoint 0 next to a freely configured endpoint, and same-cycle collisions between events and clears. It also covers the address being held across a staged write until the endpoint-0 IN pulse arrives.

// File: rtl/usbd_ep_regs.sv
module usbd_ep_regs #(
  parameter int NUM_EP = 16,
  parameter int ADDR_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_req,
  input  logic                  bus_we,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  output logic                  bus_rvalid,
  input  logic [2*NUM_EP-1:0]   hw_prime_ack,
  input  logic [2*NUM_EP-1:0]   hw_flush_ack,
  input  logic [2*NUM_EP-1:0]   hw_ready_set,
  input  logic [2*NUM_EP-1:0]   hw_ready_clr,
  input  logic [2*NUM_EP-1:0]   hw_complete,
  input  logic [NUM_EP-1:0]     hw_setup,
  input  logic                  hw_bus_reset,
  input  logic                  hw_port_change,
  input  logic                  hw_error,
  input  logic                  hw_ep0_in_done,
  output logic [2*NUM_EP-1:0]   prime_req,
  output logic [2*NUM_EP-1:0]   flush_req,
  output logic [2*NUM_EP-1:0]   ep_en,
  output logic [2*NUM_EP-1:0]   ep_stall,
  output logic [4*NUM_EP-1:0]   ep_type,
  output logic [2*NUM_EP-1:0]   ep_toggle_rst,
  output logic [6:0]            dev_addr,
  output logic                  run,
  output logic                  dev_mode
);
  localparam int BM_W  = 2*NUM_EP;
  localparam int EPI_W = (NUM_EP > 1) ? $clog2(NUM_EP) : 1;
  localparam logic [ADDR_W-1:0] A_CMD   = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] A_ADDR  = ADDR_W'('h08);
  localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'('h0C);
  localparam logic [ADDR_W-1:0] A_SETUP = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] A_PRIME = ADDR_W'('h14);
  localparam logic [ADDR_W-1:0] A_FLUSH = ADDR_W'('h18);
  localparam logic [ADDR_W-1:0] A_READY = ADDR_W'('h1C);
  localparam logic [ADDR_W-1:0] A_CMPL  = ADDR_W'('h20);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'('h40);
  localparam logic [ADDR_W-1:0] CTRL_SPAN = ADDR_W'(4*NUM_EP);

  wire wr = bus_req & bus_we;
  wire rd = bus_req & ~bus_we;

  wire [ADDR_W-1:0] ctrl_off = bus_addr - A_CTRL;
  wire              ctrl_hit = (bus_addr >= A_CTRL) && (ctrl_off < CTRL_SPAN) && (ctrl_off[1:0] == 2'b00);
  wire [EPI_W-1:0]  ctrl_idx = EPI_W'(ctrl_off >> 2);
  wire              ctrl_wr  = wr & ctrl_hit;

  wire soft_rst = wr && (bus_addr == A_CMD) && bus_wdata[1];

  logic              run_q;
  logic [1:0]        mode_q;
  logic [3:0]        stat_q;
  logic [6:0]        addr_q, addr_new_q;
  logic              stage_q;
  logic [NUM_EP-1:0] setup_q;
  logic [BM_W-1:0]   prime_q, flush_q, ready_q, cmpl_q;

  logic [NUM_EP-1:0]      rx_en, tx_en, rx_stall, tx_stall;
  logic [NUM_EP-1:0][1:0] rx_type, tx_type;

  wire [3:0] stat_ev  = {hw_bus_reset, hw_port_change, hw_error, (|hw_complete) | (|hw_setup)};
  wire [3:0] stat_clr = (wr && bus_addr == A_STAT) ? {bus_wdata[6], bus_wdata[2], bus_wdata[1], bus_wdata[0]} : 4'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      mode_q <= 2'b0;
      stat_q <= 4'b0;
    end else if (soft_rst) begin
      run_q  <= 1'b0;
      mode_q <= 2'b0;
      stat_q <= 4'b0;
    end else begin
      if (wr && bus_addr == A_CMD)  run_q  <= bus_wdata[0];
      if (wr && bus_addr == A_MODE) mode_q <= bus_wdata[1:0];
      stat_q <= (stat_q & ~stat_clr) | stat_ev;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q     <= 7'd0;
      addr_new_q <= 7'd0;
      stage_q    <= 1'b0;
    end else if (soft_rst) begin
      addr_q     <= 7'd0;
      addr_new_q <= 7'd0;
      stage_q    <= 1'b0;
    end else if (wr && bus_addr == A_ADDR) begin
      addr_new_q <= bus_wdata[31:25];
      stage_q    <= bus_wdata[24];
      if (!bus_wdata[24]) addr_q <= bus_wdata[31:25];
    end else if (stage_q && hw_ep0_in_done) begin
      addr_q  <= addr_new_q;
      stage_q <= 1'b0;
    end
  end

  wire [BM_W-1:0]   prime_set = (wr && bus_addr == A_PRIME) ? bus_wdata[BM_W-1:0] : '0;
  wire [BM_W-1:0]   flush_set = (wr && bus_addr == A_FLUSH) ? bus_wdata[BM_W-1:0] : '0;
  wire [BM_W-1:0]   cmpl_clr  = (wr && bus_addr == A_CMPL)  ? bus_wdata[BM_W-1:0] : '0;
  wire [NUM_EP-1:0] setup_clr = (wr && bus_addr == A_SETUP) ? bus_wdata[NUM_EP-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prime_q <= '0;
      flush_q <= '0;
      ready_q <= '0;
      cmpl_q  <= '0;
      setup_q <= '0;
    end else if (soft_rst) begin
      prime_q <= '0;
      flush_q <= '0;
      ready_q <= '0;
      cmpl_q  <= '0;
      setup_q <= '0;
    end else begin
      prime_q <= (prime_q & ~hw_prime_ack) | prime_set;
      flush_q <= (flush_q & ~hw_flush_ack) | flush_set;
      ready_q <= (ready_q & ~hw_ready_clr) | hw_ready_set;
      cmpl_q  <= (cmpl_q & ~cmpl_clr) | hw_complete;
      setup_q <= (setup_q & ~setup_clr) | hw_setup;
    end
  end

  for (genvar n = 0; n < NUM_EP; n++) begin : g_ep
    wire sel = ctrl_wr && (ctrl_idx == EPI_W'(n));
    logic rxs, txs, rxt, txt;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rxs <= 1'b0; txs <= 1'b0; rxt <= 1'b0; txt <= 1'b0;
      end else if (soft_rst) begin
        rxs <= 1'b0; txs <= 1'b0; rxt <= 1'b0; txt <= 1'b0;
      end else begin
        rxt <= sel & bus_wdata[6];
        txt <= sel & bus_wdata[22];
        if (sel) begin
          rxs <= bus_wdata[0];
          txs <= bus_wdata[16];
        end
      end
    end

    assign rx_stall[n]          = rxs;
    assign tx_stall[n]          = txs;
    assign ep_toggle_rst[n]        = rxt;
    assign ep_toggle_rst[NUM_EP+n] = txt;

    if (n == 0) begin : g_fixed
      assign rx_en[n]   = 1'b1;
      assign tx_en[n]   = 1'b1;
      assign rx_type[n] = 2'd0;
      assign tx_type[n] = 2'd0;
    end else begin : g_cfg
      logic       rxe, txe;
      logic [1:0] rxty, txty;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rxe <= 1'b0; txe <= 1'b0; rxty <= 2'd0; txty <= 2'd0;
        end else if (soft_rst) begin
          rxe <= 1'b0; txe <= 1'b0; rxty <= 2'd0; txty <= 2'd0;
        end else if (sel) begin
          rxe  <= bus_wdata[7];
          txe  <= bus_wdata[23];
          rxty <= bus_wdata[3:2];
          txty <= bus_wdata[19:18];
        end
      end
      assign rx_en[n]   = rxe;
      assign tx_en[n]   = txe;
      assign rx_type[n] = rxty;
      assign tx_type[n] = txty;
    end

    assign ep_en[n]             = rx_en[n];
    assign ep_en[NUM_EP+n]      = tx_en[n];
    assign ep_stall[n]          = rx_stall[n];
    assign ep_stall[NUM_EP+n]   = tx_stall[n];
    assign ep_type[2*n +: 2]          = rx_type[n];
    assign ep_type[2*(NUM_EP+n) +: 2] = tx_type[n];
  end

  wire [31:0] ctrl_rd = {8'h00, tx_en[ctrl_idx], 3'b000, tx_type[ctrl_idx], 1'b0, tx_stall[ctrl_idx],
                         8'h00, rx_en[ctrl_idx], 3'b000, rx_type[ctrl_idx], 1'b0, rx_stall[ctrl_idx]};

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = 32'h0;
    if (ctrl_hit)                   rd_mux = ctrl_rd;
    else if (bus_addr == A_CMD)     rd_mux = {31'h0, run_q};
    else if (bus_addr == A_STAT)    rd_mux = {25'h0, stat_q[3], 3'b000, stat_q[2:0]};
    else if (bus_addr == A_ADDR)    rd_mux = {addr_new_q, stage_q, 24'h0};
    else if (bus_addr == A_MODE)    rd_mux = {30'h0, mode_q};
    else if (bus_addr == A_SETUP)   rd_mux = 32'(setup_q);
    else if (bus_addr == A_PRIME)   rd_mux = 32'(prime_q);
    else if (bus_addr == A_FLUSH)   rd_mux = 32'(flush_q);
    else if (bus_addr == A_READY)   rd_mux = 32'(ready_q);
    else if (bus_addr == A_CMPL)    rd_mux = 32'(cmpl_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= 32'h0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd;
      if (rd) bus_rdata <= rd_mux;
    end
  end

  assign prime_req = prime_q;
  assign flush_req = flush_q;
  assign dev_addr  = addr_q;
  assign run       = run_q;
  assign dev_mode  = (mode_q == 2'd2);
endmodule

// File: rtl/usbd_ep_regs_chk.sv
module usbd_ep_regs_chk #(
  parameter int NUM_EP = 16,
  parameter int ADDR_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_req,
  input logic                bus_we,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [31:0]         bus_wdata,
  input logic [2*NUM_EP-1:0] hw_prime_ack,
  input logic [2*NUM_EP-1:0] hw_flush_ack,
  input logic                hw_ep0_in_done,
  input logic [2*NUM_EP-1:0] prime_req,
  input logic [2*NUM_EP-1:0] flush_req,
  input logic [2*NUM_EP-1:0] ep_stall,
  input logic [2*NUM_EP-1:0] ep_toggle_rst,
  input logic [6:0]          dev_addr
);
  localparam int CTRL_LO = 'h40;
  localparam int CTRL_HI = 'h40 + 4*NUM_EP;

  wire w       = bus_req && bus_we;
  wire w_prime = w && (32'(bus_addr) == 32'h14);
  wire w_flush = w && (32'(bus_addr) == 32'h18);
  wire w_srst  = w && (32'(bus_addr) == 32'h00) && bus_wdata[1];
  wire w_aimm  = w && (32'(bus_addr) == 32'h08) && !bus_wdata[24];
  wire w_ctrl  = w && (32'(bus_addr) >= CTRL_LO) && (32'(bus_addr) < CTRL_HI);

  AST_PRIME_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !w_prime |=> ((prime_req & $past(hw_prime_ack)) == '0)); // R3

  AST_PRIME_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !w_srst |=> (($past(prime_req & ~hw_prime_ack) & ~prime_req) == '0)); // R3

  AST_FLUSH_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !w_flush |=> ((flush_req & $past(hw_flush_ack)) == '0)); // R4

  AST_TOGGLE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (ep_toggle_rst != '0) |-> $past(w_ctrl)); // R8

  AST_STALL_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ep_stall) |-> ($past(w_ctrl) || $past(w_srst))); // R8

  AST_ADDR_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dev_addr) |-> ($past(w_aimm) || $past(hw_ep0_in_done) || $past(w_srst))); // R10
endmodule

bind usbd_ep_regs usbd_ep_regs_chk #(.NUM_EP(NUM_EP), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .hw_prime_ack(hw_prime_ack), .hw_flush_ack(hw_flush_ack),
  .hw_ep0_in_done(hw_ep0_in_done), .prime_req(prime_req), .flush_req(flush_req),
  .ep_stall(ep_stall), .ep_toggle_rst(ep_toggle_rst), .dev_addr(dev_addr)
);

// File: tb/usbd_ep_regs_tb.sv
`timescale 1ns/1ps
module usbd_ep_regs_tb;
  localparam int NUM_EP = 16;
  localparam int ADDR_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_req = 1'b0, bus_we = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic bus_rvalid;
  logic [31:0] hw_prime_ack = '0, hw_flush_ack = '0, hw_ready_set = '0, hw_ready_clr = '0, hw_complete = '0;
  logic [15:0] hw_setup = '0;
  logic hw_bus_reset = 1'b0, hw_port_change = 1'b0, hw_error = 1'b0, hw_ep0_in_done = 1'b0;
  logic [31:0] prime_req, flush_req, ep_en, ep_stall, ep_toggle_rst;
  logic [63:0] ep_type;
  logic [6:0] dev_addr;
  logic run, dev_mode;

  always #2 clk = ~clk;

  usbd_ep_regs #(.NUM_EP(NUM_EP), .ADDR_W(ADDR_W)) u_dut (.*);

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input int a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = ADDR_W'(a);
    @(negedge clk);
    bus_req = 1'b0;
  endtask

  task automatic idle(input int c);
    for (int i = 0; i < c; i++) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (bus_rvalid) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R1: unexpected read data actual %h expected none", bus_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(64'(bus_rdata), 64'(e), t);
      end
    end
  end

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);

    rd('h14, 32'h0, "R1 prime reset");
    rd('h04, 32'h0, "R1 status reset");
    rd('h08, 32'h0, "R1 address reset");
    rd('h40, 32'h00800080, "R9 ctrl0 reset");
    rd('h30, 32'h0, "R1 unmapped");
    check(64'(ep_en), 64'h00010001, "R9 ep0 enabled");

    wr('h14, 32'h00030001);
    check(64'(prime_req), 64'h00030001, "R2 prime set");
    wr('h14, 32'h00000004);
    check(64'(prime_req), 64'h00030005, "R2 zeros keep bits");
    hw_prime_ack = 32'h00010001; idle(1); hw_prime_ack = '0;
    check(64'(prime_req), 64'h00020004, "R3 ack clears");
    idle(2);
    rd('h14, 32'h00020004, "R3 unacked stay");

    wr('h18, 32'h00010002);
    check(64'(flush_req), 64'h00010002, "R4 flush set");
    hw_flush_ack = 32'h2; idle(1); hw_flush_ack = '0;
    check(64'(flush_req), 64'h00010000, "R4 flush ack");

    rd('h1C, 32'h0, "R5 ready not from prime");
    hw_ready_set = 32'h00020000; idle(1); hw_ready_set = '0;
    rd('h1C, 32'h00020000, "R5 ready set");
    hw_ready_clr = 32'h00020000; idle(1); hw_ready_clr = '0;
    rd('h1C, 32'h0, "R5 ready clr");

    hw_complete = 32'h00080008; idle(1); hw_complete = '0;
    rd('h20, 32'h00080008, "R6 complete set");
    rd('h04, 32'h1, "R7 transfer bit");
    wr('h20, 32'h00000008);
    rd('h20, 32'h00080000, "R6 complete w1c");
    hw_complete = 32'h00080000;
    wr('h20, 32'h00080000);
    hw_complete = '0;
    rd('h20, 32'h00080000, "R6 event wins");
    hw_setup = 16'h0004; idle(1); hw_setup = '0;
    rd('h10, 32'h4, "R6 setup set");
    wr('h10, 32'hFFFFFFFF);
    rd('h10, 32'h0, "R6 setup w1c");

    wr('h04, 32'h1);
    hw_bus_reset = 1'b1; hw_error = 1'b1; idle(1); hw_bus_reset = 1'b0; hw_error = 1'b0;
    rd('h04, 32'h42, "R7 reset+error bits");
    hw_port_change = 1'b1;
    wr('h04, 32'h46);
    hw_port_change = 1'b0;
    rd('h04, 32'h04, "R7 event wins");

    wr('h4C, 32'h00C900CC);
    check(64'(ep_toggle_rst), 64'h00080008, "R8 toggle pulse");
    idle(1);
    check(64'(ep_toggle_rst), 64'h0, "R8 toggle one cycle");
    rd('h4C, 32'h0089008C, "R8 ctrl readback");
    check(64'(ep_en), 64'h00090009, "R8 ep_en");
    check(64'(ep_type[7:6]), 64'd3, "R8 out type");
    check(64'(ep_type[39:38]), 64'd2, "R8 in type");
    wr('h40, 32'hFFFFFFFF);
    rd('h40, 32'h00810081, "R9 ctrl0 fixed");
    check(64'(ep_stall), 64'h00090001, "R9 ep0 stall");
    wr('h40, 32'h0);
    check(64'(ep_en), 64'h00090009, "R9 ep0 stays enabled");

    wr('h08, {7'd5, 1'b1, 24'h0});
    check(64'(dev_addr), 64'd0, "R10 staged hold");
    idle(3);
    check(64'(dev_addr), 64'd0, "R10 staged still");
    rd('h08, 32'h0B000000, "R10 pending read");
    hw_ep0_in_done = 1'b1; idle(1); hw_ep0_in_done = 1'b0;
    check(64'(dev_addr), 64'd5, "R10 commit");
    rd('h08, 32'h0A000000, "R10 stage cleared");
    wr('h08, {7'd9, 1'b0, 24'h0});
    check(64'(dev_addr), 64'd9, "R10 immediate");

    wr('h0C, 32'h2);
    check(64'(dev_mode), 64'd1, "R12 device mode");
    rd('h0C, 32'h2, "R12 mode read");
    wr('h0C, 32'h3);
    check(64'(dev_mode), 64'd0, "R12 other mode");

    wr('h00, 32'h1);
    check(64'(run), 64'd1, "R11 run");
    rd('h00, 32'h1, "R11 run read");
    wr('h00, 32'h3);
    check(64'(run), 64'd0, "R11 soft reset run");
    check(64'(prime_req), 64'h0, "R11 soft reset prime");
    check(64'(ep_en), 64'h00010001, "R11 soft reset ctrl");
    check(64'(dev_addr), 64'd0, "R11 soft reset addr");
    rd('h00, 32'h0, "R11 reset bit reads 0");
    rd('h20, 32'h0, "R11 soft reset complete");

    idle(4);
    check(64'(exp_q.size()), 64'd0, "R1 all reads returned");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule